// File: doc/BRIEF.md
# Reconfigurable Unit Configuration Controller

This block couples a small processor's control unit to a reconfigurable functional unit. The processor issues three kinds of command: a load command that configures the unit, a compute command that hands it two operands, and a capture command that collects the answer. A load fetches the configuration stream from a configuration cache one word at a time. Each fetch is a request and response handshake. Each fetched word is then pushed into the unit's serial configuration chain, one bit per cycle. The processor sees an acknowledge only once the final bit has gone in.

The compute and capture commands are only honoured once a configuration is present. An operand adapter drives the unit's input pads from the two operands. The controller then stays busy for a fixed result latency. The capture command copies the unit's output pads into the result register. While a load or a latency wait is in progress, the controller reports busy, and any command held on its input waits until it is accepted.

Top module: `rfu_cfg_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `cfg_valid`, `res`, `cache_req` and `cfg_shift_en`, and abandons any load in progress.
- R2: A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low. `cmd_op` is decoded as 2'b01 load, 2'b10 compute, 2'b11 capture and 2'b00 no operation.
- R3: A load requests words at `cache_addr` 0, 1, 2 and so on, with a single-cycle `cache_req` per word. A word is taken when `cache_rvalid` is high. The next request is made only after the current word has been fully shifted.
- R4: Stream bit i is word i/CFG_WORD_W, bit i%CFG_WORD_W, taken LSB first. It appears on `cfg_sout` during a cycle in which `cfg_shift_en` is high. A load makes exactly CFG_BITS shifts, so the unused upper bits of the last word are never shifted.
- R5: `set_ack` pulses for one cycle, in the same cycle in which `cfg_valid` rises, and only after the last configuration bit.
- R6: `busy` stays high for the whole load. A second load command held during a load is accepted only after the first load's acknowledge.
- R7: An accepted compute with a configuration present drives `pad_in` to {op2, op1}, with op1 in the low DATA_W bits. It pulses `op_ack`. It then keeps `busy` high for exactly RES_LAT cycles after the accepting edge.
- R8: An accepted capture with a configuration present loads `pad_out` into `res` and pulses `op_ack`.
- R9: A compute or capture accepted while `cfg_valid` is low pulses `op_err` instead of `op_ack`. It leaves `res` unchanged and starts no latency wait.
- R10: A load accepted while configured drops `cfg_valid` until the new load completes. Later compute and capture commands use the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present, held until accepted |
| cmd_op | input | 2 | Command code |
| cmd_op1 | input | DATA_W | First operand |
| cmd_op2 | input | DATA_W | Second operand |
| busy | output | 1 | Load or result wait in progress; commands are held off |
| cfg_valid | output | 1 | A complete configuration is loaded |
| set_ack | output | 1 | One-cycle load-complete acknowledge |
| op_ack | output | 1 | One-cycle compute/capture acknowledge |
| op_err | output | 1 | One-cycle compute/capture rejected, no configuration |
| cache_req | output | 1 | Word request to configuration cache |
| cache_addr | output | addr_w(CFG_BITS,CFG_WORD_W) | Word index requested |
| cache_rvalid | input | 1 | Cache returns the requested word |
| cache_rdata | input | CFG_WORD_W | Returned configuration word |
| cfg_shift_en | output | 1 | Configuration chain shift enable |
| cfg_sout | output | 1 | Serial configuration bit |
| pad_in | output | 2*DATA_W | Operand pads of the unit |
| pad_out | input | DATA_W | Result pads of the unit |
| res | output | DATA_W | Result register |

## Verification
The assertions assume three things about the inputs: the cache answers only a request that is pending, the unit's result pads settle within RES_LAT cycles of the operand pads changing, and a command is held steady until it is accepted. The bench keeps to these assumptions. Its cache model answers exactly one cycle after each request, with one response per request. Its unit model runs the configured function through a pipeline exactly RES_LAT stages deep. Its command task changes inputs only on falling edges and keeps them in place until busy has been seen low.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_SET   = 2'b01,
    CMD_EXEC  = 2'b10,
    CMD_STORE = 2'b11
  } cmd_e;

  typedef enum logic {
    ST_IDLE,
    ST_LOAD
  } ctl_e;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_WAIT,
    LD_SHIFT
  } ld_e;

  function automatic int addr_w(input int bits, input int ww);
    int n;
    n = (bits + ww - 1) / ww;
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rcc_loader.sv
module rcc_loader
  import rcc_pkg::*;
#(
  parameter int CFG_BITS = 36,
  parameter int WORD_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  output logic                              cache_req,
  output logic [addr_w(CFG_BITS,WORD_W)-1:0] cache_addr,
  input  logic                              cache_rvalid,
  input  logic [WORD_W-1:0]                 cache_rdata,
  output logic                              shift_en,
  output logic                              shift_bit,
  output logic                              done
);

  localparam int AW  = addr_w(CFG_BITS, WORD_W);
  localparam int BCW = $clog2(CFG_BITS);
  localparam int WCW = $clog2(WORD_W);
  localparam logic [BCW-1:0] LAST_BIT  = BCW'(CFG_BITS - 1);
  localparam logic [WCW-1:0] LAST_WBIT = WCW'(WORD_W - 1);

  ld_e              st;
  logic [WORD_W-1:0] sreg;
  logic [BCW-1:0]   bitcnt;
  logic [WCW-1:0]   wbit;
  logic [AW-1:0]    addr;
  logic             req_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= LD_IDLE;
      sreg   <= '0;
      bitcnt <= '0;
      wbit   <= '0;
      addr   <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (st)
        LD_IDLE: begin
          if (start) begin
            addr   <= '0;
            bitcnt <= '0;
            req_q  <= 1'b1;
            st     <= LD_WAIT;
          end
        end
        LD_WAIT: begin
          if (cache_rvalid) begin
            sreg <= cache_rdata;
            wbit <= '0;
            st   <= LD_SHIFT;
          end
        end
        LD_SHIFT: begin
          sreg   <= sreg >> 1;
          bitcnt <= bitcnt + 1'b1;
          wbit   <= wbit + 1'b1;
          if (bitcnt == LAST_BIT) begin
            done_q <= 1'b1;
            st     <= LD_IDLE;
          end else if (wbit == LAST_WBIT) begin
            addr  <= addr + 1'b1;
            req_q <= 1'b1;
            st    <= LD_WAIT;
          end
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

  assign cache_req  = req_q;
  assign cache_addr = addr;
  assign shift_en   = (st == LD_SHIFT);
  assign shift_bit  = sreg[0];
  assign done       = done_q;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cache_req |=> !cache_req);
  assert_req_not_shifting_R3: assert property (@(posedge clk) disable iff (rst)
    cache_req |-> !shift_en);
  assert_bit_range_R4: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (bitcnt <= LAST_BIT));
  assert_done_follows_shift_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(shift_en));

endmodule

// File: rtl/rcc_timer.sv
module rcc_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= CW'(LAT);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  assert_countdown_R7: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> (cnt == $past(cnt) - 1'b1));
  assert_load_arms_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> active);

endmodule

// File: rtl/rcc_adapter.sv
module rcc_adapter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_ops,
  input  logic [DW-1:0] op1,
  input  logic [DW-1:0] op2,
  input  logic          cap_res,
  input  logic [DW-1:0] pads_out,
  output logic [2*DW-1:0] pads_in,
  output logic [DW-1:0] res
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pads_in <= '0;
      res     <= '0;
    end else begin
      if (cap_ops) pads_in <= {op2, op1};
      if (cap_res) res     <= pads_out;
    end
  end

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cap_res |=> $stable(res));
  assert_pads_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cap_ops |=> $stable(pads_in));

endmodule

// File: rtl/rfu_cfg_ctrl.sv
module rfu_cfg_ctrl
  import rcc_pkg::*;
#(
  parameter int CFG_BITS   = 36,
  parameter int CFG_WORD_W = 8,
  parameter int DATA_W     = 8,
  parameter int RES_LAT    = 3
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     cmd_valid,
  input  logic [1:0]                               cmd_op,
  input  logic [DATA_W-1:0]                        cmd_op1,
  input  logic [DATA_W-1:0]                        cmd_op2,
  output logic                                     busy,
  output logic                                     cfg_valid,
  output logic                                     set_ack,
  output logic                                     op_ack,
  output logic                                     op_err,
  output logic                                     cache_req,
  output logic [addr_w(CFG_BITS,CFG_WORD_W)-1:0]   cache_addr,
  input  logic                                     cache_rvalid,
  input  logic [CFG_WORD_W-1:0]                    cache_rdata,
  output logic                                     cfg_shift_en,
  output logic                                     cfg_sout,
  output logic [2*DATA_W-1:0]                      pad_in,
  input  logic [DATA_W-1:0]                        pad_out,
  output logic [DATA_W-1:0]                        res
);

  ctl_e st;
  cmd_e op;
  logic accept, go_set, exec_ok, store_ok, bad_op;
  logic ld_done, tmr_active;
  logic valid_q, set_ack_q, op_ack_q, err_q;

  assign op       = cmd_e'(cmd_op);
  assign busy     = (st == ST_LOAD) || tmr_active;
  assign accept   = cmd_valid && !busy;
  assign go_set   = accept && (op == CMD_SET);
  assign exec_ok  = accept && (op == CMD_EXEC)  && valid_q;
  assign store_ok = accept && (op == CMD_STORE) && valid_q;
  assign bad_op   = accept && ((op == CMD_EXEC) || (op == CMD_STORE)) && !valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      valid_q   <= 1'b0;
      set_ack_q <= 1'b0;
      op_ack_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      set_ack_q <= 1'b0;
      op_ack_q  <= exec_ok || store_ok;
      err_q     <= bad_op;
      case (st)
        ST_IDLE: begin
          if (go_set) begin
            st      <= ST_LOAD;
            valid_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (ld_done) begin
            st        <= ST_IDLE;
            valid_q   <= 1'b1;
            set_ack_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  rcc_loader #(.CFG_BITS(CFG_BITS), .WORD_W(CFG_WORD_W)) u_loader (
    .clk          (clk),
    .rst          (rst),
    .start        (go_set),
    .cache_req    (cache_req),
    .cache_addr   (cache_addr),
    .cache_rvalid (cache_rvalid),
    .cache_rdata  (cache_rdata),
    .shift_en     (cfg_shift_en),
    .shift_bit    (cfg_sout),
    .done         (ld_done)
  );

  rcc_timer #(.LAT(RES_LAT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (exec_ok),
    .active (tmr_active)
  );

  rcc_adapter #(.DW(DATA_W)) u_adapter (
    .clk      (clk),
    .rst      (rst),
    .cap_ops  (exec_ok),
    .op1      (cmd_op1),
    .op2      (cmd_op2),
    .cap_res  (store_ok),
    .pads_out (pad_out),
    .pads_in  (pad_in),
    .res      (res)
  );

  assign cfg_valid = valid_q;
  assign set_ack   = set_ack_q;
  assign op_ack    = op_ack_q;
  assign op_err    = err_q;

  assert_ack_with_valid_R5: assert property (@(posedge clk) disable iff (rst)
    set_ack |-> cfg_valid);
  assert_valid_rise_acked_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> set_ack);
  assert_shift_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_shift_en |-> busy);
  assert_err_keeps_res_R9: assert property (@(posedge clk) disable iff (rst)
    op_err |-> $stable(res));
  assert_err_unconfigured_R9: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (!cfg_valid && !op_ack));

endmodule

// File: tb/test_rfu_cfg_ctrl.sv
module test_rfu_cfg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CB  = 36;
  localparam int WW  = 8;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int NW  = 5;
  localparam int NV  = 6;

  // {sel[1:0], mask[7:0], op1, op2, expected res}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h12, 8'h34, 8'h46},
    {2'd1, 8'h00, 8'hF0, 8'h3C, 8'hCC},
    {2'd2, 8'h00, 8'h10, 8'h20, 8'hF0},
    {2'd3, 8'h00, 8'hF3, 8'h3F, 8'h33},
    {2'd0, 8'hFF, 8'h80, 8'h90, 8'hEF},
    {2'd1, 8'h0F, 8'hAA, 8'h55, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [DW-1:0] cmd_op1 = '0, cmd_op2 = '0;
  logic busy, cfg_valid, set_ack, op_ack, op_err, cache_req;
  logic [2:0] cache_addr;
  logic cache_rvalid;
  logic [WW-1:0] cache_rdata;
  logic cfg_shift_en, cfg_sout;
  logic [2*DW-1:0] pad_in;
  logic [DW-1:0] pad_out;
  logic [DW-1:0] res;

  int n_run = 0, n_fail = 0;
  int nshift = 0, nacks = 0, nreq = 0;
  logic [2:0] req_log [16];
  logic [WW-1:0] mem [NW];
  logic [CB-1:0] chain = '0;
  logic [DW-1:0] pipe [LAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  rfu_cfg_ctrl #(.CFG_BITS(CB), .CFG_WORD_W(WW), .DATA_W(DW), .RES_LAT(LAT)) i_rfu_cfg_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_op1(cmd_op1), .cmd_op2(cmd_op2), .busy(busy), .cfg_valid(cfg_valid),
    .set_ack(set_ack), .op_ack(op_ack), .op_err(op_err), .cache_req(cache_req),
    .cache_addr(cache_addr), .cache_rvalid(cache_rvalid), .cache_rdata(cache_rdata),
    .cfg_shift_en(cfg_shift_en), .cfg_sout(cfg_sout), .pad_in(pad_in),
    .pad_out(pad_out), .res(res)
  );

  // configuration cache: one response, one cycle after each request
  always @(posedge clk) begin
    if (rst) begin
      cache_rvalid <= 1'b0;
      cache_rdata  <= '0;
    end else begin
      cache_rvalid <= cache_req;
      if (cache_req) cache_rdata <= (cache_addr < 3'(NW)) ? mem[cache_addr] : '0;
    end
  end

  // reconfigurable unit model: serial chain plus LAT-deep function pipeline
  function automatic logic [DW-1:0] unit_fn(input logic [CB-1:0] c, input logic [2*DW-1:0] p);
    logic [DW-1:0] a, b, r;
    a = p[DW-1:0];
    b = p[2*DW-1:DW];
    case (c[1:0])
      2'd0: r = a + b;
      2'd1: r = a ^ b;
      2'd2: r = a - b;
      default: r = a & b;
    endcase
    return r ^ c[15:8];
  endfunction

  always @(posedge clk) begin
    if (cfg_shift_en) begin
      chain  <= {cfg_sout, chain[CB-1:1]};
      nshift <= nshift + 1;
    end
    if (set_ack) nacks <= nacks + 1;
    if (cache_req && nreq < 16) begin
      req_log[nreq] <= cache_addr;
      nreq <= nreq + 1;
    end
    pipe[0] <= unit_fn(chain, pad_in);
    for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
  end
  assign pad_out = pipe[LAT-1];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk_cfg(input logic [1:0] sel, input logic [7:0] mask);
    return {4'hF, 20'h5A3C9, mask, 6'b101101, sel};
  endfunction

  task automatic fill_mem(input logic [39:0] v);
    for (int k = 0; k < NW; k++) mem[k] = v[8*k +: 8];
  endtask

  task automatic issue(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_op1 = a; cmd_op2 = b;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_ack();
    while (!set_ack) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [39:0] v;
    int n;
    fill_mem(mk_cfg(2'd0, 8'h00));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 cfg_valid", cfg_valid, 0);
    check("R1 res", res, 0);
    check("R1 cache_req", cache_req, 0);
    check("R1 shift_en", cfg_shift_en, 0);

    // R9 compute and capture before any configuration
    issue(2'b10, 8'h11, 8'h22);
    check("R9 exec err", op_err, 1);
    check("R9 exec no ack", op_ack, 0);
    check("R9 no latency wait", busy, 0);
    issue(2'b11, 8'h00, 8'h00);
    check("R9 store err", op_err, 1);
    check("R9 res unchanged", res, 0);

    // R2/R3/R4/R6 load, with a second load held off behind it
    v = mk_cfg(2'd1, 8'h3C);
    fill_mem(v);
    nshift = 0; nacks = 0; nreq = 0;
    issue(2'b01, 8'h00, 8'h00);
    check("R6 busy during load", busy, 1);
    check("R2 load accepted", cfg_valid, 0);
    issue(2'b01, 8'h00, 8'h00);
    check("R6 second load waits for ack", nacks, 1);
    check("R4 shift count", nshift, CB);
    check("R4 chain contents", chain, v[CB-1:0]);
    check("R3 request count", nreq, NW);
    for (int k = 0; k < NW; k++) check("R3 request order", req_log[k], k);
    wait_ack();
    check("R5 valid with ack", cfg_valid, 1);
    @(negedge clk);
    check("R5 ack single cycle", set_ack, 0);
    check("R6 second load shifts", nshift, 2*CB);

    // vector table: R7, R8, R10
    for (int i = 0; i < NV; i++) begin
      v = mk_cfg(VEC[i][33:32], VEC[i][31:24]);
      fill_mem(v);
      issue(2'b01, 8'h00, 8'h00);
      check("R10 valid drops on reload", cfg_valid, 0);
      wait_ack();
      check("R5 configured", cfg_valid, 1);
      issue(2'b10, VEC[i][23:16], VEC[i][15:8]);
      check("R7 exec ack", op_ack, 1);
      check("R7 pad_in", pad_in, {VEC[i][15:8], VEC[i][23:16]});
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R7 latency cycles", n, LAT);
      issue(2'b11, 8'h00, 8'h00);
      check("R8 store ack", op_ack, 1);
      check("R8 res", res, VEC[i][7:0]);
    end

    // R1 reset during a load
    issue(2'b01, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 busy after mid-load reset", busy, 0);
    check("R1 cfg_valid after reset", cfg_valid, 0);
    check("R1 res after reset", res, 0);
    @(negedge clk);
    check("R1 no shift after reset", cfg_shift_en, 0);
    summary();
  end

endmodule